// File: doc/BRIEF.md
# Timestamp Frame Interrupt Sequencer

This block is a small bus master. It replaces a processor on the register port of a network timing endpoint and runs a periodic time-sync master exchange with no software. It connects to a single-outstanding request/acknowledge register bus. Once reset is released, it programs the real-time clock increment. After that it waits in idle for one of three level-sensitive interrupt lines: a periodic timer tick, a transmit-done event and a receive event.

Each interrupt starts a fixed sequence of register accesses. A timer tick requests a sync frame and then clears the tick. A transmit-done event triggers a read of the transmit status word. If that word reports a sync frame, the block asks for a follow-up frame. A receive event triggers a single read of the receive status word. The status reads also serve as the interrupt acknowledges. The block does not build frame contents or look at received frames. The clock, the MAC and their registers sit outside it.

Top module: `ts_irq_sequencer`

## Requirements
- R1: After reset the first bus transaction is a write of the clock increment (default 0x0000_0028) to the clock configuration address (default 0x000). No interrupt is serviced before that write is acknowledged.
- R2: A timer interrupt produces exactly two writes, in this order: 0x1 (sync request bit 0) to the transmit request address 0x100, then 0x1 to the timer clear address 0x104.
- R3: A transmit interrupt starts with a read (write-enable low) of the transmit status address 0x108. No separate clear write follows for it.
- R4: If the transmit status read returns frame type 0 (sync) in bits [3:0], the next transaction writes 0x2 (follow-up request bit 1) to 0x100. Bits above [3:0] are ignored.
- R5: If the transmit status read returns any other frame type, no further transaction follows the read.
- R6: A receive interrupt produces exactly one read of the receive status address 0x10C and nothing else.
- R7: The block holds address, write-enable and write data unchanged while the request is high and the acknowledge is low. Each acknowledge completes one transaction.
- R8: When interrupts are pending in idle, the block serves them in this order: transmit, then timer, then receive. Each is re-evaluated only after the current sequence returns to idle.
- R9: Busy is high from reset until initialization ends and throughout every service sequence. It is low in idle. The request is never high while busy is low.
- R10: While reset is held, the request is low and busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_timer | input | 1 | Periodic timer interrupt, level |
| irq_tx | input | 1 | Transmit-done interrupt, level |
| irq_rx | input | 1 | Receive interrupt, level |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Transaction acknowledge; read data valid in this cycle |
| bus_rdata | input | DW | Read data |
| busy | output | 1 | Initialization or service sequence in progress |

## Verification
The hardest situation to reach from the ports is several interrupts pending at once with a transmit status that varies. In that case the transmit service and its chained follow-up must finish before the timer and receive sequences start. The bench raises every non-empty combination of the three interrupt lines in the same cycle. It crosses these with all sixteen frame-type codes and four acknowledge latencies. A register model clears each line on the acknowledging access, and the recorded transaction list is compared with a list computed from the priority rules. A separate run raises the timer line during initialization to show that the clock write comes first.

// File: rtl/ts_irq_sequencer.sv
module ts_irq_sequencer #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [AW-1:0] A_CLKCFG = 'h000,
  parameter logic [DW-1:0] CLKCFG_VAL = 'h28,
  parameter logic [AW-1:0] A_TXREQ = 'h100,
  parameter logic [AW-1:0] A_TMRCLR = 'h104,
  parameter logic [AW-1:0] A_TXSTAT = 'h108,
  parameter logic [AW-1:0] A_RXSTAT = 'h10C,
  parameter logic [DW-1:0] REQ_SYNC = 'h1,
  parameter logic [DW-1:0] REQ_FUP = 'h2,
  parameter logic [DW-1:0] TMRCLR_VAL = 'h1,
  parameter int TYPE_LSB = 0,
  parameter int TYPE_W = 4,
  parameter int TYPE_SYNC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_timer,
  input  logic          irq_tx,
  input  logic          irq_rx,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy
);
  typedef enum logic [2:0] {
    S_BOOT, S_CFG, S_IDLE, S_TSYNC, S_TCLR, S_TXST, S_FUP, S_RXST
  } st_t;

  st_t st, nxt;

  wire is_sync = bus_rdata[TYPE_LSB +: TYPE_W] == TYPE_W'(TYPE_SYNC);

  assign bus_req = (st != S_BOOT) && (st != S_IDLE);
  assign busy    = (st != S_IDLE);

  always_comb begin
    nxt = st;
    case (st)
      S_BOOT:  nxt = S_CFG;
      S_CFG:   if (bus_ack) nxt = S_IDLE;
      S_IDLE:  if (irq_tx) nxt = S_TXST;
               else if (irq_timer) nxt = S_TSYNC;
               else if (irq_rx) nxt = S_RXST;
      S_TSYNC: if (bus_ack) nxt = S_TCLR;
      S_TCLR:  if (bus_ack) nxt = S_IDLE;
      S_TXST:  if (bus_ack) nxt = is_sync ? S_FUP : S_IDLE;
      S_FUP:   if (bus_ack) nxt = S_IDLE;
      S_RXST:  if (bus_ack) nxt = S_IDLE;
      default: nxt = S_BOOT;
    endcase
  end

  always_comb begin
    bus_we    = 1'b1;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_CFG:   begin bus_addr = A_CLKCFG; bus_wdata = CLKCFG_VAL; end
      S_TSYNC: begin bus_addr = A_TXREQ;  bus_wdata = REQ_SYNC; end
      S_TCLR:  begin bus_addr = A_TMRCLR; bus_wdata = TMRCLR_VAL; end
      S_FUP:   begin bus_addr = A_TXREQ;  bus_wdata = REQ_FUP; end
      S_TXST:  begin bus_addr = A_TXSTAT; bus_we = 1'b0; end
      S_RXST:  begin bus_addr = A_RXSTAT; bus_we = 1'b0; end
      default: bus_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (!rst_n) st <= S_BOOT;
    else        st <= nxt;
endmodule

// File: rtl/ts_irq_sequencer_chk.sv
module ts_irq_sequencer_chk #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [AW-1:0] A_CLKCFG = 'h000,
  parameter logic [DW-1:0] CLKCFG_VAL = 'h28,
  parameter logic [AW-1:0] A_TXREQ = 'h100,
  parameter logic [AW-1:0] A_TMRCLR = 'h104,
  parameter logic [AW-1:0] A_TXSTAT = 'h108,
  parameter logic [AW-1:0] A_RXSTAT = 'h10C,
  parameter logic [DW-1:0] REQ_SYNC = 'h1,
  parameter logic [DW-1:0] REQ_FUP = 'h2,
  parameter int TYPE_LSB = 0,
  parameter int TYPE_W = 4,
  parameter int TYPE_SYNC = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic [DW-1:0] bus_rdata,
  input logic          busy
);
  logic cfg_done;
  always_ff @(posedge clk)
    if (!rst_n) cfg_done <= 1'b0;
    else if (bus_req && bus_ack) cfg_done <= 1'b1;

  wire done = bus_req && bus_ack;
  wire rd_sync = bus_rdata[TYPE_LSB +: TYPE_W] == TYPE_W'(TYPE_SYNC);

  a_r1_cfg_first: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !cfg_done |-> bus_we && bus_addr == A_CLKCFG && bus_wdata == CLKCFG_VAL);

  a_r2_clear_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    done && cfg_done && bus_we && bus_addr == A_TXREQ && bus_wdata == REQ_SYNC
    |=> bus_req && bus_we && bus_addr == A_TMRCLR);

  a_r3_status_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_addr == A_TXSTAT |-> !bus_we);

  a_r4_followup: assert property (@(posedge clk) disable iff (!rst_n)
    done && !bus_we && bus_addr == A_TXSTAT && rd_sync
    |=> bus_req && bus_we && bus_addr == A_TXREQ && bus_wdata == REQ_FUP);

  a_r5_other_type_stops: assert property (@(posedge clk) disable iff (!rst_n)
    done && !bus_we && bus_addr == A_TXSTAT && !rd_sync |=> !bus_req);

  a_r6_rx_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    done && !bus_we && bus_addr == A_RXSTAT |=> !bus_req);

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r9_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);
endmodule

bind ts_irq_sequencer ts_irq_sequencer_chk #(
  .AW(AW), .DW(DW), .A_CLKCFG(A_CLKCFG), .CLKCFG_VAL(CLKCFG_VAL),
  .A_TXREQ(A_TXREQ), .A_TMRCLR(A_TMRCLR), .A_TXSTAT(A_TXSTAT), .A_RXSTAT(A_RXSTAT),
  .REQ_SYNC(REQ_SYNC), .REQ_FUP(REQ_FUP), .TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W),
  .TYPE_SYNC(TYPE_SYNC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy)
);

// File: tb/sim_ts_irq_sequencer.sv
module sim_ts_irq_sequencer;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [2:0] arm = 0;
  logic [2:0] irq;
  logic [3:0] tx_type = 0;
  int lat = 0;
  logic bus_req, bus_we, bus_ack, busy;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int cnt;

  ts_irq_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .irq_timer(irq[0]), .irq_tx(irq[1]), .irq_rx(irq[2]),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy));

  assign bus_ack = bus_req && cnt == lat;
  assign bus_rdata = bus_addr == 12'h108 ? {28'hABCD123, tx_type} :
                     bus_addr == 12'h10C ? 32'h3 : 32'h0;

  logic [44:0] lg [0:63];
  int nlog = 0, hold_err = 0, busy_err = 0;
  logic pend = 0;
  logic [44:0] pv;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0; irq <= 0; pend <= 0;
    end else begin
      irq <= irq | arm;
      if (bus_req && !busy) busy_err <= busy_err + 1;
      if (pend && (!bus_req || {bus_we, bus_addr, bus_wdata} != pv)) hold_err <= hold_err + 1;
      pend <= bus_req && !bus_ack;
      pv <= {bus_we, bus_addr, bus_wdata};
      if (bus_ack) begin
        cnt <= 0;
        lg[nlog % 64] <= {bus_we, bus_addr, bus_wdata};
        nlog <= nlog + 1;
        if (bus_we && bus_addr == 12'h104) irq[0] <= 1'b0;
        if (!bus_we && bus_addr == 12'h108) irq[1] <= 1'b0;
        if (!bus_we && bus_addr == 12'h10C) irq[2] <= 1'b0;
      end else if (bus_req) cnt <= cnt + 1;
    end
  end

  int checks = 0, fails = 0;
  logic [44:0] ex [0:7];
  int nex;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic add(input bit we, input logic [11:0] a, input logic [31:0] d);
    ex[nex] = {we, a, we ? d : 32'h0};
    nex++;
  endtask

  task automatic build(input bit init, input logic [2:0] m, input logic [3:0] ty);
    nex = 0;
    if (init) add(1, 12'h000, 32'h28);
    if (m[1]) begin
      add(0, 12'h108, 0);
      if (ty == 0) add(1, 12'h100, 32'h2);
    end
    if (m[0]) begin add(1, 12'h100, 32'h1); add(1, 12'h104, 32'h1); end
    if (m[2]) add(0, 12'h10C, 0);
  endtask

  task automatic run(input bit init, input logic [2:0] m, input string req);
    int start = nlog;
    int k = 0;
    bit ok;
    arm = m;
    @(negedge clk);
    arm = 0;
    do begin @(negedge clk); k++; end while (!(k > 2 && !busy && irq == 0) && k < 300);
    ok = (k < 300) && (nlog - start == nex);
    for (int i = 0; ok && i < nex; i++) begin
      logic [44:0] g = lg[(start + i) % 64];
      if ({g[44:32], g[44] ? g[31:0] : 32'h0} != ex[i]) ok = 0;
    end
    check(ok, req, $sformatf("m=%0d ty=%0d lat=%0d n=%0d", m, tx_type, lat, nlog - start),
          $sformatf("n=%0d", nex));
  endtask

  initial begin
    lat = 3;
    repeat (3) @(negedge clk);
    check(!bus_req && busy, "R10", $sformatf("req=%0b busy=%0b", bus_req, busy), "req=0 busy=1");
    rst_n = 1;
    build(1, 3'b001, 0);
    run(1, 3'b001, "R1 init first then R2 timer");
    check(!busy, "R9 idle busy", $sformatf("%0b", busy), "0");
    for (int l = 0; l < 4; l++)
      for (int m = 1; m < 8; m++)
        for (int t = 0; t < 16; t++) begin
          if (!m[1] && t > 0) continue;
          lat = l; tx_type = t[3:0];
          build(0, m[2:0], t[3:0]);
          run(0, m[2:0], m[1] ? (t == 0 ? "R3 R4 R8 tx sync" : "R3 R5 R8 tx other")
                              : (m[0] ? "R2 R6 R8 timer/rx" : "R6 rx"));
        end
    check(hold_err == 0, "R7 hold", $sformatf("%0d", hold_err), "0");
    check(busy_err == 0, "R9 req without busy", $sformatf("%0d", busy_err), "0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule